// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Pins

This block is a parameterised register (eight bits by default) that can hold its contents, shift toward the high end, shift toward the low end, or load a whole word in parallel. A two-bit select picks the operation, and the register acts on each rising clock edge. Each bit has one bidirectional parallel pin. That pin is both the load input and the driven output. Inside the chip the pin is split into a data-out bus, a common drive-enable and a data-in bus, and the pad or a bus mux outside the block rebuilds it.

The drive is switched off when either of two active-low output enables is high. It is also switched off whenever the parallel-load select is applied, so that outside logic can put the load word on the same pins. Two serial inputs feed the ends of the register. Two serial outputs always carry the lowest and highest bit and are never switched off, so several instances can be chained into a longer shift path. An active-low clear acts at once and takes priority over the clock and the selects.

Top module: `usr_shift_reg`

## Requirements
- R1: While `clr_n` is low, every register bit is 0. The clear takes effect without waiting for a clock edge, and while it is low no clock edge changes the register, whatever the select.
- R2: With `sel` = 2'b00 (hold), the register keeps its value across a clock edge. Changes on `pin_in` or on the serial inputs have no effect.
- R3: With `sel` = 2'b01 (shift up), a rising edge moves `ser_r_in` into bit 0 and moves bit n into bit n+1.
- R4: With `sel` = 2'b10 (shift down), a rising edge moves `ser_l_in` into bit WIDTH-1 and moves bit n into bit n-1.
- R5: With `sel` = 2'b11 (parallel load), a rising edge copies `pin_in` into the register, with bit n taken from `pin_in[n]`.
- R6: `pin_oe` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0 and `sel` is not 2'b11.
- R7: `pin_out` always carries the register contents. Hold, shift, load and clear all take effect while `pin_oe` is 0.
- R8: `ser_q_lo` always equals bit 0 and `ser_q_hi` always equals bit WIDTH-1, whatever the enables and selects.
- R9: Two instances chained with the low part's `ser_q_hi` driving the high part's `ser_r_in`, and the high part's `ser_q_lo` driving the low part's `ser_l_in`, behave as one register of twice the width in both shift directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; acts without a clock edge and overrides the selects |
| sel | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| ser_r_in | input | 1 | Serial bit entering bit 0 on a shift up |
| ser_l_in | input | 1 | Serial bit entering bit WIDTH-1 on a shift down |
| oe_a_n | input | 1 | Active-low parallel drive enable, first of two |
| oe_b_n | input | 1 | Active-low parallel drive enable, second of two |
| pin_in | input | WIDTH | Data received from the shared parallel pins |
| pin_out | output | WIDTH | Register contents to drive onto the shared pins |
| pin_oe | output | 1 | Drive enable for all parallel pins |
| ser_q_lo | output | 1 | Bit 0, never disabled |
| ser_q_hi | output | 1 | Bit WIDTH-1, never disabled |

## Verification
On every clock, the assertions check the effect of each select code on the next register value. They also check that the clear forces zero, that the drive enable follows the select and the two enables, and that the serial outputs track the end bits. Three things only the bench scenarios can show. The first is a full 16-bit shift in both directions through two chained instances. The second is a load through the pins while drive is off. The third is a clear applied between clock edges during a shift, which shows that the clear does not wait for the clock.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHUP = 2'b01,
    MODE_SHDN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_bit_cell.sv
module usr_bit_cell
  import usr_pkg::*;
(
  input  usr_mode_e mode,
  input  logic      cur_v,
  input  logic      from_below,
  input  logic      from_above,
  input  logic      par_v,
  output logic      nxt_v
);
  always_comb begin
    unique case (mode)
      MODE_HOLD: nxt_v = cur_v;
      MODE_SHUP: nxt_v = from_below;
      MODE_SHDN: nxt_v = from_above;
      MODE_LOAD: nxt_v = par_v;
      default:   nxt_v = cur_v;
    endcase
  end
endmodule

// File: rtl/usr_drive_ctrl.sv
module usr_drive_ctrl
  import usr_pkg::*;
(
  input  usr_mode_e mode,
  input  logic      oe_a_n,
  input  logic      oe_b_n,
  output logic      drv_en
);
  logic enables_on;
  logic load_pending;

  assign enables_on   = ~oe_a_n & ~oe_b_n;
  assign load_pending = (mode == MODE_LOAD);
  assign drv_en       = enables_on & ~load_pending;
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       sel,
  input  logic             ser_r_in,
  input  logic             ser_l_in,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic             pin_oe,
  output logic             ser_q_lo,
  output logic             ser_q_hi
);
  localparam int TOP = WIDTH - 1;

  usr_mode_e        mode;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_nxt;
  logic [WIDTH-1:0] below_src;
  logic [WIDTH-1:0] above_src;

  assign mode      = usr_mode_e'(sel);
  assign below_src = {q[TOP-1:0], ser_r_in};
  assign above_src = {ser_l_in, q[TOP:1]};

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    usr_bit_cell cell_i (
      .mode       (mode),
      .cur_v      (q[i]),
      .from_below (below_src[i]),
      .from_above (above_src[i]),
      .par_v      (pin_in[i]),
      .nxt_v      (q_nxt[i])
    );
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_nxt;
  end

  usr_drive_ctrl drv_i (
    .mode   (mode),
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .drv_en (pin_oe)
  );

  assign pin_out  = q;
  assign ser_q_lo = q[0];
  assign ser_q_hi = q[TOP];

  p_clear_r1: assert property (@(posedge clk) !clr_n |=> q == '0);
  p_hold_r2: assert property (@(posedge clk) disable iff (!clr_n)
    sel == 2'b00 |=> $stable(q));
  p_shup_r3: assert property (@(posedge clk) disable iff (!clr_n)
    sel == 2'b01 |=> q == {$past(q[TOP-1:0]), $past(ser_r_in)});
  p_shdn_r4: assert property (@(posedge clk) disable iff (!clr_n)
    sel == 2'b10 |=> q == {$past(ser_l_in), $past(q[TOP:1])});
  p_load_r5: assert property (@(posedge clk) disable iff (!clr_n)
    sel == 2'b11 |=> q == $past(pin_in));
  p_drive_off_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_a_n || oe_b_n || sel == 2'b11) |-> !pin_oe);
  p_drive_on_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (!oe_a_n && !oe_b_n && sel != 2'b11) |-> pin_oe);
  p_ser_ends_r8: assert property (@(posedge clk) disable iff (!clr_n)
    ser_q_lo == pin_out[0] && ser_q_hi == pin_out[TOP]);
endmodule

// File: tb/usr_shift_reg_tb_top.sv
module usr_shift_reg_tb_top;
  localparam int W      = 8;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic ser_in_r = 1'b0;
  logic ser_in_l = 1'b0;
  logic oe_a_n = 1'b0;
  logic oe_b_n = 1'b0;
  logic [W-1:0] pin_in_lo = '0;
  logic [W-1:0] pin_in_hi = '0;
  logic [W-1:0] pout_lo, pout_hi;
  logic oe_lo, oe_hi;
  logic lo_q0, lo_q7, hi_q0, hi_q7;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  usr_shift_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .clr_n(clr_n), .sel(sel), .ser_r_in(ser_in_r), .ser_l_in(hi_q0),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pin_in(pin_in_lo), .pin_out(pout_lo),
    .pin_oe(oe_lo), .ser_q_lo(lo_q0), .ser_q_hi(lo_q7)
  );

  usr_shift_reg #(.WIDTH(W)) dut_hi_i (
    .clk(clk), .clr_n(clr_n), .sel(sel), .ser_r_in(lo_q7), .ser_l_in(ser_in_l),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pin_in(pin_in_hi), .pin_out(pout_hi),
    .pin_oe(oe_hi), .ser_q_lo(hi_q0), .ser_q_hi(hi_q7)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] word();
    return {pout_hi, pout_lo};
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] model;
    repeat (3) step();
    chk("R1 reset state", 32'(word()), 32'h0);
    // R1: selects cannot load while clear is held
    sel = 2'b11; pin_in_lo = 8'hFF; pin_in_hi = 8'hFF;
    step();
    chk("R1 clear overrides load", 32'(word()), 32'h0);
    sel = 2'b00;
    clr_n = 1'b1;
    #1;

    // R6: drive enable over every select/enable combination
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++) begin
          sel = 2'(s); oe_a_n = 1'(a); oe_b_n = 1'(b);
          #1;
          chk("R6 drive enable", 32'({oe_lo, oe_hi}),
              ((a == 0 && b == 0 && s != 3) ? 32'h3 : 32'h0));
        end
    sel = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0;

    // R5/R7: load sweep through pins with drive off
    for (int v = 0; v < 256; v++) begin
      oe_a_n = 1'(v & 1);
      pin_in_lo = 8'(v); pin_in_hi = ~8'(v); sel = 2'b11;
      step();
      sel = 2'b00;
      chk("R5 parallel load", 32'(word()), 32'({~8'(v), 8'(v)}));
    end
    oe_a_n = 1'b0;
    model = word();

    // R2: hold ignores pins and serial inputs
    for (int k = 0; k < 4; k++) begin
      pin_in_lo = 8'(k * 37); pin_in_hi = 8'(k * 91 + 5);
      ser_in_r = 1'(k); ser_in_l = ~1'(k);
      step();
      chk("R2 hold", 32'(word()), 32'(model));
    end

    // R3/R9: 16-bit shift up through the chain
    sel = 2'b01;
    for (int k = 0; k < 20; k++) begin
      ser_in_r = 1'(((k * 5 + 1) % 3) == 0);
      model = {model[14:0], ser_in_r};
      step();
      chk("R3 R9 chained shift up", 32'(word()), 32'(model));
      oe_b_n = 1'(k & 1);
      chk("R8 serial ends", 32'({hi_q7, lo_q0}), 32'({model[15], model[0]}));
      oe_b_n = 1'b0;
    end

    // R4/R9: 16-bit shift down from a known pattern
    pin_in_lo = 8'hC3; pin_in_hi = 8'hA5; sel = 2'b11;
    step();
    model = 16'hA5C3;
    sel = 2'b10;
    for (int k = 0; k < 20; k++) begin
      ser_in_l = 1'((k % 4) == 1 || k == 7);
      model = {ser_in_l, model[15:1]};
      step();
      chk("R4 R9 chained shift down", 32'(word()), 32'(model));
    end

    // R7: shift with drive disabled still updates contents
    oe_a_n = 1'b1; sel = 2'b01; ser_in_r = 1'b1;
    model = {model[14:0], 1'b1};
    step();
    chk("R7 shift while drive off", 32'(word()), 32'(model));
    chk("R7 drive off", 32'({oe_lo, oe_hi}), 32'h0);
    oe_a_n = 1'b0;

    // R1: clear between edges during a shift
    #(PERIOD/4);
    clr_n = 1'b0;
    #1;
    chk("R1 clear mid-cycle", 32'(word()), 32'h0);
    step();
    chk("R1 clear held over edge", 32'(word()), 32'h0);
    clr_n = 1'b1; ser_in_r = 1'b1;
    step();
    chk("R3 shift after clear", 32'(word()), 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule